// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Timer

This block drives three complementary gate pairs, one high-side and one low-side signal for each of three phases, from a single up/down counter. The counter climbs through one half of the period and falls back through the other, so each phase's pulses are centered on the turning point of the period. Software programs the period, three duty values and a dead-time value through a small write port. Each write lands in a shadow copy. The timer moves the shadows into its active copies only at defined boundaries, so a pulse never changes width while it is in progress.

The timer does nothing until the period and all three duty values have each been written at least once since reset. Until then every gate stays low and no sync pulse appears. In single-update mode, one set of duty values serves both halves of the period. In double-update mode, the duty values are refreshed again at the turning point, so each half can have its own width and the total on-time can be set in one-clock steps. The dead time is inserted symmetrically at every edge of every pair, so the two sides of a pair are never on together.

Top module: `pwm3_timer`

## Requirements
- R1: After reset, every gate output and `sync` stay low until the period (address 0) and all three duty registers (addresses 1, 2, 3) have each been written at least once. Writing the dead-time register is not needed to start.
- R2: Counting starts in the cycle after the write that completes arming. With active period P (P ≥ 1), each PWM period lasts exactly 2·P clock cycles. `sync` is high for exactly its first cycle.
- R3: Within a period, a half-index i runs 0,1,…,P−1 and then P−1,…,1,0. With active duty D and dead time T, and with T < D < P, `gate_hi` of a phase is high when i ≥ P−D+T, and `gate_lo` is high when i < P−D−T. This gives D−T high cycles per half and an off gap of 2·T cycles at each transition.
- R4: `gate_hi` and `gate_lo` of the same phase are never high in the same cycle.
- R5: A duty D ≥ P holds the high side on and the low side off for the whole half. Otherwise, a duty D ≤ T holds the low side on and the high side off for the whole half.
- R6: A write goes to a shadow copy. The period, dead time and duty values take effect only from the next period start. A write issued in the last cycle of a period becomes active only one period later.
- R7: When `dbl_mode` is high during the last cycle of the rising half, the duty shadows are also copied into the active duties at the turning point. The period and dead time are not copied there.
- R8: In single-update mode (`dbl_mode` low), the active duty values do not change at the turning point.
- R9: The write address map is 0 = period, 1..3 = duty of phases A..C, 4 = dead time. Writes to addresses 5..7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | W | Register write data |
| dbl_mode | input | 1 | 1 = double-update mode, 0 = single-update mode |
| gate_hi | output | 3 | High-side gates, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gates, bit 0 = phase A |
| sync | output | 1 | One-cycle pulse at each period start |

## Verification
The critical coincidence is a register write that arrives in the same cycle as a shadow transfer. The transfer must take the old shadow value, and the new value must wait for the following boundary. The bench provokes this by tracking its own period position and issuing a duty write exactly in the last cycle of a period, and also during the last rising-half cycle in double-update mode. The reference model's outputs are then compared with the design's outputs on every following cycle. A wrong ordering shows up as a period whose pulse widths are off.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int unsigned NPH = 3;

  localparam logic [2:0] ADDR_PERIOD = 3'd0;
  localparam logic [2:0] ADDR_DUTY0  = 3'd1;
  localparam logic [2:0] ADDR_DEAD   = 3'd4;

  // high side on at half-index idx: fully on when duty reaches the period,
  // otherwise on in the last (duty - dead) indices of the half
  function automatic logic hi_on(input int unsigned idx, input int unsigned duty,
                                 input int unsigned per, input int unsigned dead);
    if (duty >= per) return 1'b1;
    if (duty <= dead) return 1'b0;
    return (idx + duty) >= (per + dead);
  endfunction

  // low side on at half-index idx: the complement window shrunk by dead time
  function automatic logic lo_on(input int unsigned idx, input int unsigned duty,
                                 input int unsigned per, input int unsigned dead);
    if (duty >= per) return 1'b0;
    if (duty <= dead) return 1'b1;
    return (idx + duty + dead) < per;
  endfunction
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
  import pwm3_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_addr,
  input  logic [W-1:0]          wr_data,
  input  logic                  load_all,
  input  logic                  load_mid,
  output logic                  armed,
  output logic [W-1:0]          act_period,
  output logic [W-1:0]          act_dead,
  output logic [NPH-1:0][W-1:0] act_duty
);
  localparam int unsigned NFLAG = NPH + 1;

  logic [W-1:0]           sh_period;
  logic [W-1:0]           sh_dead;
  logic [NPH-1:0][W-1:0]  sh_duty;
  logic [NFLAG-1:0]       written;

  assign armed = &written;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_period  <= '0;
      sh_dead    <= '0;
      sh_duty    <= '0;
      written    <= '0;
      act_period <= '0;
      act_dead   <= '0;
      act_duty   <= '0;
    end else begin
      if (load_all) begin
        act_period <= sh_period;
        act_dead   <= sh_dead;
        act_duty   <= sh_duty;
      end else if (load_mid) begin
        act_duty   <= sh_duty;
      end
      if (wr_en) begin
        if (wr_addr == ADDR_PERIOD) begin
          sh_period  <= wr_data;
          written[0] <= 1'b1;
        end
        if (wr_addr == ADDR_DEAD) sh_dead <= wr_data;
        for (int k = 0; k < NPH; k++) begin
          if (wr_addr == ADDR_DUTY0 + 3'(k)) begin
            sh_duty[k]   <= wr_data;
            written[k+1] <= 1'b1;
          end
        end
      end
    end
  end

  // R6: period and dead time change only through a period-start transfer
  p_period_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_all |=> $stable(act_period) && $stable(act_dead));

  // R8: duties change only at a transfer strobe
  p_duty_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_all && !load_mid) |=> $stable(act_duty));
endmodule

// File: rtl/pwm3_counter.sv
module pwm3_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         armed,
  input  logic         dbl_mode,
  input  logic [W-1:0] act_period,
  output logic         run,
  output logic         down,
  output logic [W-1:0] cnt,
  output logic         load_all,
  output logic         load_mid,
  output logic         sync
);
  logic at_mid;
  logic at_end;

  assign at_end   = run && down && (cnt == '0);
  assign at_mid   = run && !down && (({1'b0, cnt} + 1'b1) >= {1'b0, act_period});
  assign load_all = (!run && armed) || at_end;
  assign load_mid = at_mid && dbl_mode;
  assign sync     = run && !down && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      down <= 1'b0;
      cnt  <= '0;
    end else if (load_all) begin
      run  <= 1'b1;
      down <= 1'b0;
      cnt  <= '0;
    end else if (at_mid) begin
      down <= 1'b1;
    end else if (run) begin
      cnt  <= down ? cnt - 1'b1 : cnt + 1'b1;
    end
  end

  // R2: half-index never leaves 0..P-1
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && act_period != '0) |-> (cnt < act_period));

  // R2: sync lasts one cycle
  p_sync_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !sync);
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase
  import pwm3_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] period,
  input  logic [W-1:0] duty,
  input  logic [W-1:0] dead,
  output logic         hi,
  output logic         lo
);
  assign hi = run && hi_on(32'(cnt), 32'(duty), 32'(period), 32'(dead));
  assign lo = run && lo_on(32'(cnt), 32'(duty), 32'(period), 32'(dead));

  // R4: the two sides of a pair never conduct together
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi && lo));
endmodule

// File: rtl/pwm3_timer.sv
module pwm3_timer
  import pwm3_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         dbl_mode,
  output logic [2:0]   gate_hi,
  output logic [2:0]   gate_lo,
  output logic         sync
);
  logic                  armed;
  logic                  run;
  logic                  down;
  logic [W-1:0]          cnt;
  logic                  load_all;
  logic                  load_mid;
  logic [W-1:0]          act_period;
  logic [W-1:0]          act_dead;
  logic [NPH-1:0][W-1:0] act_duty;

  pwm3_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_all(load_all), .load_mid(load_mid),
    .armed(armed), .act_period(act_period), .act_dead(act_dead),
    .act_duty(act_duty)
  );

  pwm3_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .armed(armed), .dbl_mode(dbl_mode),
    .act_period(act_period), .run(run), .down(down), .cnt(cnt),
    .load_all(load_all), .load_mid(load_mid), .sync(sync)
  );

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    pwm3_phase #(.W(W)) u_ph (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
      .period(act_period), .duty(act_duty[g]), .dead(act_dead),
      .hi(gate_hi[g]), .lo(gate_lo[g])
    );
  end

  // R1: quiet until armed
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (gate_hi == 3'b000 && gate_lo == 3'b000 && !sync));
endmodule

// File: tb/pwm3_timer_bench.sv
module pwm3_timer_bench;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         dbl_mode = 1'b0;
  logic [2:0]   gate_hi;
  logic [2:0]   gate_lo;
  logic         sync;

  always #5 clk = ~clk;

  pwm3_timer #(.W(W)) u_pwm3_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dbl_mode(dbl_mode), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .sync(sync)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  int sp, st, sd[3];
  int ap, at, ad[3];
  bit wflag[4];
  bit running;
  int t;

  function automatic int span_hi(int p, int d, int dt);
    if (d >= p) return p;
    if (d <= dt) return 0;
    return d - dt;
  endfunction

  function automatic int span_lo(int p, int d, int dt);
    int r;
    if (d >= p) return 0;
    if (d <= dt) return p;
    r = p - d - dt;
    return (r < 0) ? 0 : r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp = 0; st = 0; ap = 0; at = 0; running = 0; t = 0;
      for (int k = 0; k < 3; k++) begin sd[k] = 0; ad[k] = 0; end
      for (int k = 0; k < 4; k++) wflag[k] = 0;
    end else begin
      if (!running) begin
        if (wflag[0] && wflag[1] && wflag[2] && wflag[3]) begin
          running = 1; t = 0; ap = sp; at = st;
          for (int k = 0; k < 3; k++) ad[k] = sd[k];
        end
      end else begin
        t = t + 1;
        if (t >= 2 * ap) begin
          t = 0; ap = sp; at = st;
          for (int k = 0; k < 3; k++) ad[k] = sd[k];
        end else if (t == ap && dbl_mode) begin
          for (int k = 0; k < 3; k++) ad[k] = sd[k];
        end
      end
      if (wr_en) begin
        case (int'(wr_addr))
          0: begin sp = int'(wr_data); wflag[0] = 1; end
          1, 2, 3: begin sd[int'(wr_addr) - 1] = int'(wr_data); wflag[int'(wr_addr)] = 1; end
          4: st = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [2:0] eh, el;
    logic       es;
    int         i;
    if (rst_n && !done) begin
      eh = '0; el = '0; es = 0;
      if (running) begin
        i  = (t < ap) ? t : 2 * ap - 1 - t;
        es = (t == 0);
        for (int k = 0; k < 3; k++) begin
          eh[k] = (i >= ap - span_hi(ap, ad[k], at));
          el[k] = (i < span_lo(ap, ad[k], at));
        end
      end
      n_chk++;
      if (gate_hi !== eh || gate_lo !== el || sync !== es) begin
        n_bad++;
        $display("FAIL %s t=%0d hi/lo/sync=%b/%b/%b expected %b/%b/%b",
                 cur_req, t, gate_hi, gate_lo, sync, eh, el, es);
      end
      n_chk++;
      if ((gate_hi & gate_lo) !== 3'b000) begin
        n_bad++;
        $display("FAIL R4 overlap hi=%b lo=%b expected no common bit", gate_hi, gate_lo);
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait until the model sits at position pos of the running period
  task automatic wait_pos(input int pos);
    do @(negedge clk); while (!(running && t == pos));
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired, expected run to end");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt_s;
    idle(3);
    n_chk++;
    if (gate_hi !== 0 || gate_lo !== 0 || sync !== 0) begin
      n_bad++;
      $display("FAIL R1 reset outputs %b/%b/%b expected 000/000/0", gate_hi, gate_lo, sync);
    end
    rst_n = 1;
    // R1: partial programming leaves the block idle
    cur_req = "R1";
    wr(0, 20); wr(4, 2); wr(1, 10); wr(2, 5);
    idle(30);
    // R2/R3: final duty write arms the timer
    cur_req = "R3";
    wr(3, 3);
    idle(200);
    // R2: five sync pulses in five periods of 40 cycles
    cur_req = "R2";
    wait_pos(0);
    cnt_s = 0;
    for (int k = 0; k < 200; k++) begin
      if (sync) cnt_s++;
      @(negedge clk);
    end
    n_chk++;
    if (cnt_s != 5) begin
      n_bad++;
      $display("FAIL R2 sync count %0d expected 5", cnt_s);
    end
    // R5: clamps, full-on and full-off duty
    cur_req = "R5";
    wr(1, 20); wr(2, 2); wr(3, 25);
    idle(120);
    // R6: mid-period writes held to the next period start
    cur_req = "R6";
    wait_pos(7);
    wr_en = 1; wr_addr = 3'd1; wr_data = W'(12);
    @(negedge clk); wr_en = 0;
    wr(4, 4); wr(0, 16);
    idle(100);
    // R6: write landing in the last cycle of a period
    wait_pos(2 * ap - 1);
    wr_en = 1; wr_addr = 3'd2; wr_data = W'(9);
    @(negedge clk); wr_en = 0;
    idle(100);
    // R8: single update mode ignores a mid-period duty change until restart
    cur_req = "R8";
    wait_pos(3);
    wr_en = 1; wr_addr = 3'd3; wr_data = W'(6);
    @(negedge clk); wr_en = 0;
    idle(80);
    // R7: double update mode, distinct duties per half
    cur_req = "R7";
    dbl_mode = 1;
    for (int k = 0; k < 6; k++) begin
      wait_pos(2);
      wr(1, 5 + k); wr(2, 14 - k);
      wait_pos(ap + 2);
      wr(1, 11 - k); wr(3, 7 + k);
    end
    // R7: write exactly in the last rising-half cycle
    wait_pos(ap - 1);
    wr_en = 1; wr_addr = 3'd1; wr_data = W'(3);
    @(negedge clk); wr_en = 0;
    idle(100);
    // R9: unused addresses change nothing
    cur_req = "R9";
    wr(5, 1); wr(6, 0); wr(7, 4095);
    idle(100);
    // R2: short period of one
    cur_req = "R2";
    dbl_mode = 0;
    wr(0, 1); wr(4, 0); wr(1, 1); wr(2, 0); wr(3, 0);
    idle(60);
    // R3: larger period, mid-range duties
    cur_req = "R3";
    wr(0, 300); wr(4, 7); wr(1, 150); wr(2, 8); wr(3, 292);
    idle(2000);
    done = 1;
    summary();
    $finish;
  end
endmodule